// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block runs a bit-serial mod-2 division for a cyclic redundancy check. The generator polynomial and its degree n are loaded when a frame starts. Bits enter most significant first on a valid/ready input stream. In generate mode every message bit is copied to a valid/ready output stream, and the n-bit check sequence follows it, so the output carries T = M·x^n + R. In check mode the whole received frame goes in and nothing comes out. At the end a done pulse fires, and an error flag is raised if the frame does not divide exactly by the generator.

A single remainder register serves both modes. Message bits drive the feedback division. An end-of-message marker on the last message bit switches the block into a phase that lasts n bits. In generate mode that phase shifts the remainder out. In check mode it compares the remainder against the received check bits. The frame remainder is zero exactly when every received check bit equals the computed one. Both streams follow the usual rule: a transfer takes place on a clock edge where valid and ready are both high. A source that is stalled holds its bit. In generate mode the input can only move when the output can, so back-pressure on the output stalls the input.

Top module: `crc_serial_unit`

## Requirements
- R1: After reset, and in the cycle after `frame_start`, `done` and `error` are low. While no frame is active, `in_ready` and `out_valid` stay low. Asserting `frame_start` clears the remainder and latches `check_mode`, `gen_degree` and `gen_poly`. No bit is transferred in the cycle where `frame_start` is high.
- R2: In generate mode (`check_mode` = 0), during the message phase, `out_valid` equals `in_valid`, `out_bit` equals `in_bit`, and `in_ready` equals `out_ready`. Every accepted message bit therefore appears on the output in the same cycle.
- R3: In generate mode, after the bit that carries `in_last`, the output sends n check bits, most significant first. They equal the remainder of M·x^n divided by the generator. Message 1010001101 with generator 110101 gives 01110.
- R4: While `out_valid` is high and `out_ready` is low during the check-sequence phase, `out_valid` stays high and `out_bit` keeps its value in the next cycle.
- R5: In check mode (`check_mode` = 1), `in_ready` is high and `out_valid` is low for the whole frame. The n bits after the `in_last` bit are taken as the check sequence. `error` is raised exactly when the full frame leaves a nonzero remainder.
- R6: `done` is high for exactly one cycle. That cycle directly follows the edge that transfers the final check bit. `error` is valid from that cycle and holds until the next `frame_start`.
- R7: Bit i of `gen_poly` is the coefficient of x^i for i < n. The x^n coefficient is implied, and bits at position n and above are ignored. `gen_degree` may be any value from 1 to MAX_DEG.
- R8: In check mode, inverting any single bit of a correctly generated frame raises `error`, provided the generator detects that error position.
- R9: `in_valid` while no frame is active has no effect. `in_last` is ignored during the check-sequence phase.
- R10: A `frame_start` in the middle of a frame abandons that frame. The new frame's result is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | Starts a frame and latches the mode and generator |
| check_mode | input | 1 | 0 = generate, 1 = check |
| gen_degree | input | $clog2(MAX_DEG+1) | Generator degree n |
| gen_poly | input | MAX_DEG | Low n generator coefficients |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Input bit accepted when high with in_valid |
| in_bit | input | 1 | Serial input bit |
| in_last | input | 1 | Marks the last message bit |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Downstream can take the output bit |
| out_bit | output | 1 | Serial output bit |
| done | output | 1 | One-cycle end-of-frame pulse |
| error | output | 1 | Frame remainder nonzero (check mode) |

## Verification
A corrupted remainder bit does not reach the ports until the phase change. From there it shows up in generate mode as a wrong check bit in the cycle that bit is emitted, and in check mode as a wrong `error` on the `done` pulse. A wrong phase counter or degree latch shows up as a check sequence of the wrong length, so `done` arrives too early or too late. The directed cases therefore cover degree 1, the maximum degree and a range of message lengths. They also flip every bit position of a known frame.

// File: rtl/crc_pkg.sv
package crc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MSG  = 2'd1,
    ST_FCS  = 2'd2
  } crc_state_e;

  typedef enum logic {
    MODE_GEN = 1'b0,
    MODE_CHK = 1'b1
  } crc_mode_e;
endpackage

// File: rtl/crc_div_engine.sv
module crc_div_engine #(
  parameter int MAX_DEG = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic [$clog2(MAX_DEG+1)-1:0] deg_in,
  input  logic [MAX_DEG-1:0]           poly_in,
  input  logic                         op_div,
  input  logic                         op_shift,
  input  logic                         din,
  output logic                         msb
);
  localparam int DW = $clog2(MAX_DEG + 1);

  logic [MAX_DEG-1:0] rem_q, mask_q, poly_q, top_q;
  logic [MAX_DEG-1:0] mask_d, top_d;
  logic               fb;

  // Active-width mask and top-bit selector for the requested degree
  for (genvar g = 0; g < MAX_DEG; g++) begin : g_sel
    assign mask_d[g] = (DW'(g) < deg_in);
    assign top_d[g]  = (DW'(g + 1) == deg_in);
  end

  assign msb = |(rem_q & top_q);
  assign fb  = din ^ msb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      mask_q <= '0;
      poly_q <= '0;
      top_q  <= '0;
    end else if (clear) begin
      rem_q  <= '0;
      mask_q <= mask_d;
      poly_q <= poly_in & mask_d;
      top_q  <= top_d;
    end else if (op_div) begin
      rem_q <= ((rem_q << 1) & mask_q) ^ (fb ? poly_q : '0);
    end else if (op_shift) begin
      rem_q <= (rem_q << 1) & mask_q;
    end
  end

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (rem_q == '0));
  p_ops_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_div && op_shift));
  p_rem_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q & ~mask_q) == '0);
endmodule

// File: rtl/crc_frame_ctrl.sv
module crc_frame_ctrl
  import crc_pkg::*;
#(
  parameter int MAX_DEG = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sof,
  input  logic                         mode_in,
  input  logic [$clog2(MAX_DEG+1)-1:0] deg_in,
  input  logic                         in_valid,
  input  logic                         in_bit,
  input  logic                         in_last,
  input  logic                         out_ready,
  input  logic                         eng_msb,
  output logic                         in_ready,
  output logic                         out_valid,
  output logic                         out_bit,
  output logic                         op_div,
  output logic                         op_shift,
  output logic                         done,
  output logic                         error
);
  localparam int DW = $clog2(MAX_DEG + 1);

  crc_state_e    state_q;
  crc_mode_e     mode_q;
  logic [DW-1:0] cnt_q;
  logic          mism_q, done_q, err_q;
  logic          fire, bit_mism;

  assign bit_mism = (mode_q == MODE_CHK) && (in_bit ^ eng_msb);

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_bit   = 1'b0;
    fire      = 1'b0;
    if (!sof) begin
      case (state_q)
        ST_MSG: begin
          if (mode_q == MODE_GEN) begin
            out_valid = in_valid;
            out_bit   = in_bit;
            in_ready  = out_ready;
          end else begin
            in_ready = 1'b1;
          end
          fire = in_valid && in_ready;
        end
        ST_FCS: begin
          if (mode_q == MODE_GEN) begin
            out_valid = 1'b1;
            out_bit   = eng_msb;
            fire      = out_ready;
          end else begin
            in_ready = 1'b1;
            fire     = in_valid;
          end
        end
        default: ;
      endcase
    end
  end

  assign op_div   = fire && (state_q == ST_MSG);
  assign op_shift = fire && (state_q == ST_FCS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_GEN;
      cnt_q   <= '0;
      mism_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (sof) begin
        state_q <= ST_MSG;
        mode_q  <= crc_mode_e'(mode_in);
        cnt_q   <= deg_in;
        mism_q  <= 1'b0;
        err_q   <= 1'b0;
      end else begin
        case (state_q)
          ST_MSG: if (fire && in_last) state_q <= ST_FCS;
          ST_FCS: if (fire) begin
            mism_q <= mism_q | bit_mism;
            cnt_q  <= cnt_q - 1'b1;
            if (cnt_q == DW'(1)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              err_q   <= mism_q | bit_mism;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign done  = done_q;
  assign error = err_q;

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_err_cleared_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !error);
  p_err_rises_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done);
  p_fcs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FCS && out_valid && !out_ready && !sof)
      |=> (sof || (out_valid && $stable(out_bit))));
  p_check_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CHK) |-> !out_valid);
endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit #(
  parameter int MAX_DEG = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_start,
  input  logic                         check_mode,
  input  logic [$clog2(MAX_DEG+1)-1:0] gen_degree,
  input  logic [MAX_DEG-1:0]           gen_poly,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic                         in_bit,
  input  logic                         in_last,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic                         out_bit,
  output logic                         done,
  output logic                         error
);
  logic eng_msb, op_div, op_shift;

  crc_frame_ctrl #(.MAX_DEG(MAX_DEG)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sof      (frame_start),
    .mode_in  (check_mode),
    .deg_in   (gen_degree),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .in_last  (in_last),
    .out_ready(out_ready),
    .eng_msb  (eng_msb),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_bit  (out_bit),
    .op_div   (op_div),
    .op_shift (op_shift),
    .done     (done),
    .error    (error)
  );

  crc_div_engine #(.MAX_DEG(MAX_DEG)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (frame_start),
    .deg_in  (gen_degree),
    .poly_in (gen_poly),
    .op_div  (op_div),
    .op_shift(op_shift),
    .din     (in_bit),
    .msb     (eng_msb)
  );
endmodule

// File: tb/crc_serial_unit_bench.sv
module crc_serial_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0, check_mode = 1'b0;
  logic [5:0]  gen_degree = '0;
  logic [31:0] gen_poly = '0;
  logic        in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic        in_ready, out_valid, out_bit, done, error;
  int          total = 0, fails = 0;

  always #4 clk = ~clk;

  crc_serial_unit #(.MAX_DEG(32)) u_crc_serial_unit (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .check_mode(check_mode),
    .gen_degree(gen_degree), .gen_poly(gen_poly), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit), .done(done), .error(error)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Plain long division of bits[len-1:0] (MSB first) followed by extra zeros
  function automatic logic [31:0] ref_div(input int deg, input logic [31:0] poly,
      input int len, input logic [287:0] bits, input int extra);
    logic [32:0] r = '0;
    logic [32:0] full;
    full = ({1'b0, poly} & ((33'd1 << deg) - 33'd1)) | (33'd1 << deg);
    for (int k = 0; k < len + extra; k++) begin
      r = (r << 1) | 33'((k < len) ? bits[len-1-k] : 1'b0);
      if (r[deg]) r = r ^ full;
    end
    return r[31:0];
  endfunction

  function automatic logic [287:0] rand_bits(input int len);
    logic [287:0] v = '0;
    for (int k = 0; k < len; k++) v[k] = 1'($urandom);
    return v;
  endfunction

  task automatic start_frame(input bit chk, input int deg, input logic [31:0] poly);
    frame_start = 1'b1; check_mode = chk; gen_degree = 6'(deg); gen_poly = poly;
    in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    #1;
    check(error === 1'b0 && done === 1'b0, "R1", "flags after frame_start", {error, done}, 0);
  endtask

  task automatic run_gen(input int deg, input logic [31:0] poly, input int len,
                         input logic [287:0] msg, input bit stall, input string req);
    logic [31:0] rem;
    int i = 0, got = 0, bad = 0;
    bit pst = 0;
    logic pbit = 0, ex;
    rem = ref_div(deg, poly, len, msg, deg);
    start_frame(0, deg, poly);
    while (got < len + deg && bad < 1000) begin
      in_valid  = (i < len);
      in_bit    = (i < len) ? msg[len-1-i] : 1'b0;
      in_last   = (i == len - 1);
      out_ready = stall ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (pst && !(out_valid === 1'b1 && out_bit === pbit)) bad++;            // R4
      if (i < len && (in_ready !== out_ready || out_valid !== 1'b1)) bad++;   // R2
      pst  = out_valid && !out_ready;
      pbit = out_bit;
      if (out_valid && out_ready) begin
        ex = (got < len) ? msg[len-1-got] : rem[deg-1-(got-len)];
        if (out_bit !== ex) bad++;
        got++;
      end
      if (in_valid && in_ready) i++;
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    check(bad == 0, req, "generated stream mismatches", bad, 0);
    check(done === 1'b1 && error === 1'b0, "R6", "done after last check bit", {done, error}, 2);
    @(negedge clk);
    check(done === 1'b0, "R6", "done single cycle", done, 0);
  endtask

  task automatic run_chk(input int deg, input logic [31:0] poly, input int len,
                         input logic [287:0] msg, input int flip, input bit gaps,
                         input bit noise, input string req);
    logic [287:0] frame;
    logic [31:0]  rem;
    logic         exp_err;
    int n, i = 0, bad = 0;
    rem   = ref_div(deg, poly, len, msg, deg);
    frame = (msg << deg) | 288'(rem);
    n     = len + deg;
    if (flip >= 0) frame[flip] = ~frame[flip];
    exp_err = (ref_div(deg, poly, n, frame, 0) != 0);
    start_frame(1, deg, poly);
    while (i < n) begin
      in_valid  = gaps ? (($urandom % 4) != 0) : 1'b1;
      in_bit    = frame[n-1-i];
      in_last   = (i == len - 1) || (noise && i >= len);
      out_ready = 1'b0;
      #1;
      if (in_ready !== 1'b1 || out_valid !== 1'b0) bad++;
      if (done !== 1'b0) bad++;
      if (in_valid) i++;
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    check(bad == 0, "R5", "check-mode handshake", bad, 0);
    check(done === 1'b1 && error === exp_err, req, "error at done", {done, error}, {1'b1, exp_err});
    @(negedge clk);
  endtask

  task automatic test_reset;
    check(in_ready === 0 && out_valid === 0 && done === 0 && error === 0, "R1",
          "reset outputs", {in_ready, out_valid, done, error}, 0);
  endtask

  task automatic test_vector;
    logic [287:0] m = 288'(10'b1010001101);
    check(ref_div(5, 32'h15, 10, m, 5) == 32'b01110, "R3", "model remainder",
          ref_div(5, 32'h15, 10, m, 5), 5'b01110);
    run_gen(5, 32'h15, 10, m, 0, "R3");
    run_gen(5, 32'h15, 10, m, 1, "R4");
    run_chk(5, 32'h15, 10, m, -1, 0, 0, "R5");
    for (int f = 0; f < 15; f++) run_chk(5, 32'h15, 10, m, f, 0, 0, "R8");
  endtask

  task automatic test_random_gen;
    int degs[4] = '{1, 8, 17, 32};
    foreach (degs[k]) begin
      int len = 1 + ($urandom % 150);
      logic [31:0] p = $urandom | 32'h1;
      run_gen(degs[k], p, len, rand_bits(len), 1, "R7");
      run_gen(degs[k], p, len, rand_bits(len), 0, "R2");
    end
  endtask

  task automatic test_random_chk;
    for (int k = 0; k < 6; k++) begin
      int d = 1 + ($urandom % 32);
      int len = 1 + ($urandom % 120);
      logic [31:0] p = $urandom | 32'h1;
      logic [287:0] m = rand_bits(len);
      run_chk(d, p, len, m, -1, 1, 0, "R5");
      run_chk(d, p, len, m, $urandom % (len + d), 1, 0, "R8");
    end
  endtask

  task automatic test_ignore;
    in_valid = 1'b1; in_last = 1'b1; out_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      check(in_ready === 0 && out_valid === 0 && done === 0, "R9", "idle ignores input",
            {in_ready, out_valid, done}, 0);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    run_chk(12, 32'h80F, 40, rand_bits(40), -1, 0, 1, "R9");
  endtask

  task automatic test_error_hold;
    run_chk(5, 32'h15, 10, 288'(10'b1010001101), 3, 0, 0, "R6");
    repeat (3) @(negedge clk);
    check(error === 1'b1, "R6", "error held after done", error, 1);
  endtask

  task automatic test_abort;
    start_frame(1, 7, 32'h09);
    in_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin in_bit = k[0]; @(negedge clk); end
    in_valid = 1'b0;
    run_gen(5, 32'h15, 10, 288'(10'b1010001101), 0, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset;
    rst_n = 1'b1;
    @(negedge clk);
    test_vector;
    test_random_gen;
    test_random_chk;
    test_ignore;
    test_error_hold;
    test_abort;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule